// File: doc/BRIEF.md
# Serial Converter Command Port

This block is the digital side of a multiplexed sampling converter's serial port. A host drives a chip-select, a serial clock and a serial data line. Each transaction carries one 8-bit command in its first eight clocks. The command either starts a conversion, which also picks a multiplexer channel and an output word layout, or changes the sign-bit and acquisition-time settings, or is a plain read. While the command shifts in, the block shifts out the result of the conversion started most recently before this transaction. The word length of each transaction follows the layout chosen in an earlier one.

The host may pulse chip-select around every transaction, or hold it low and count clocks. With the select held low, the block counts exactly one word length per frame and starts the next frame at once. All port inputs are synchronous to the system clock, and the serial clock is edge-detected against it. A built-in stub stands in for the analog converter, so every result can be predicted from the channel and the number of conversions started so far.

Top module: `adcif_serial_slave`

## Requirements
- R1: After reset the layout is 12 data bits with sign, MSB first, and the frame length is 13. The acquisition setting reads 10 clocks, the mux channel is 0, and the held result is all zeros.
- R2: The bit sampled on the first rising serial clock of a frame is command bit 7. A command with bit 7 set starts a conversion, and conv_start pulses once, one system clock after the eighth rising serial clock. In such a command, bits 6:5 select the resolution (01 gives 8 bits, 10 gives 16 bits, 00 or 11 gives 12 bits), bit 4 set means LSB first, and bits 3:0 give the channel.
- R3: A command with bits 7:6 = 01 sets the sign bit from bit 5 and the acquisition time from bits 4:3 (00, 01, 10, 11 give 6, 10, 18, 34 clocks). It starts no conversion and leaves the resolution, order and channel as they were.
- R4: A command with bits 7:6 = 00 is a read. It starts no conversion and changes no setting.
- R5: Conversion k (counting from 0 after reset) on channel c yields sign = k[0] and 16 data bits {c, k[7:0] XOR 0xA5, c}. The word shifted out in a transaction comes from the last conversion started before that transaction began.
- R6: The frame length is the number of data bits (8, 12 or 16), plus one when the sign is on. The same length applies to MSB-first and LSB-first order.
- R7: A change of resolution, order or sign takes effect from the next frame, never the current one.
- R8: In MSB-first order with the sign on, the sign goes out first, followed by the top data bits from the most significant down. When fewer than 16 bits are sent, only the upper data bits go out.
- R9: In LSB-first order the least significant data bit goes out first, and the sign, when on, goes out last.
- R10: While chip-select stays low, a frame ends on exactly the frame-length-th rising serial clock. frame_done pulses once for it, and the next clock begins a new frame with a new command.
- R11: A rising chip-select after at least one serial clock ends the frame and pulses frame_done. If fewer than eight clocks were seen, the partial command is dropped. A read with the select strobed needs only 8 clocks.
- R12: mux_sel changes only when a conversion starts.
- R13: While chip-select is high, sdo is 0 and serial clock edges have no effect. Within a frame, bit i is on sdo while the serial clock is low before its i-th rising edge, counting from 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip-select |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial command input |
| sdo | output | 1 | Serial result output |
| mux_sel | output | 4 | Channel of the last conversion started |
| acq_cycles | output | 6 | Acquisition time in serial clocks |
| frame_done | output | 1 | One-cycle pulse at the end of each frame |
| conv_start | output | 1 | One-cycle pulse when a conversion starts |

## Verification
The bench changes the layout and then checks that the current frame keeps its old length and bit order. A design that applied a new layout at once would end that frame early or scramble its bits. With chip-select held low, it confirms that no frame ends one clock early and that back-to-back frames with different lengths each end on their own count; an off-by-one counter would pull every later frame out of step. It also aborts a command after five clocks and toggles the serial clock while deselected. A design that decoded partial commands, or shifted while idle, would start conversions or send a rotated word.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    localparam int INSTR_W = 8;
    localparam int DATA_W  = 16;
    localparam int WORD_W  = DATA_W + 1;
    localparam int CHAN_W  = 4;
    localparam int SEQ_W   = 8;
    localparam int CNT_W   = $clog2(WORD_W + 1);
    localparam int ACQ_W   = 6;

    typedef enum logic [1:0] {
        KIND_READ    = 2'd0,
        KIND_SETUP   = 2'd1,
        KIND_CONVERT = 2'd2
    } kind_e;

    typedef struct packed {
        logic [1:0] res;
        logic       lsb_first;
        logic       sign_on;
    } fmt_t;

    typedef struct packed {
        kind_e             kind;
        logic [1:0]        res;
        logic              lsb_first;
        logic [CHAN_W-1:0] chan;
        logic              sign_on;
        logic [1:0]        acq;
    } cmd_t;

    localparam fmt_t       FMT_RESET = '{res: 2'b00, lsb_first: 1'b0, sign_on: 1'b1};
    localparam logic [1:0] ACQ_RESET = 2'b01;

    function automatic logic [CNT_W-1:0] data_bits(input logic [1:0] res);
        case (res)
            2'b01:   return CNT_W'(8);
            2'b10:   return CNT_W'(16);
            default: return CNT_W'(12);
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(input fmt_t f);
        return data_bits(f.res) + CNT_W'(f.sign_on);
    endfunction

    function automatic logic [ACQ_W-1:0] acq_clocks(input logic [1:0] code);
        case (code)
            2'b00:   return ACQ_W'(6);
            2'b01:   return ACQ_W'(10);
            2'b10:   return ACQ_W'(18);
            default: return ACQ_W'(34);
        endcase
    endfunction

endpackage

// File: rtl/adcif_decoder.sv
module adcif_decoder
    import adcif_pkg::*;
(
    input  logic [INSTR_W-1:0] cmd_word,
    output cmd_t               cmd
);

    always_comb begin
        if (cmd_word[7]) begin
            cmd.kind = KIND_CONVERT;
        end else if (cmd_word[6]) begin
            cmd.kind = KIND_SETUP;
        end else begin
            cmd.kind = KIND_READ;
        end
        cmd.res       = cmd_word[6:5];
        cmd.lsb_first = cmd_word[4];
        cmd.chan      = cmd_word[CHAN_W-1:0];
        cmd.sign_on   = cmd_word[5];
        cmd.acq       = cmd_word[4:3];
    end

endmodule

// File: rtl/adcif_stub_source.sv
module adcif_stub_source
    import adcif_pkg::*;
#(
    parameter int SRC_CHAN_W = CHAN_W,
    parameter int SRC_SEQ_W  = SEQ_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              fire,
    input  logic [SRC_CHAN_W-1:0]             chan,
    output logic [2*SRC_CHAN_W+SRC_SEQ_W:0]   value
);

    localparam logic [SRC_SEQ_W-1:0] SEQ_MASK = SRC_SEQ_W'('hA5);

    logic [SRC_SEQ_W-1:0] seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (fire) begin
            seq_d = seq_q + SRC_SEQ_W'(1);
        end
        value = {seq_q[0], chan, seq_q ^ SEQ_MASK, chan};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/adcif_word_builder.sv
module adcif_word_builder
    import adcif_pkg::*;
(
    input  fmt_t              fmt,
    input  logic [WORD_W-1:0] value,
    output logic [WORD_W-1:0] word
);

    for (genvar i = 0; i < WORD_W; i++) begin : g_slot
        int               nb;
        int               j;
        logic [CNT_W-1:0] pos;
        logic             use_val;
        logic             bit_val;

        always_comb begin
            nb      = int'(data_bits(fmt.res));
            j       = i;
            pos     = '0;
            use_val = 1'b0;
            if (!fmt.lsb_first) begin
                if (fmt.sign_on && (i == 0)) begin
                    pos     = CNT_W'(WORD_W - 1);
                    use_val = 1'b1;
                end else begin
                    j = fmt.sign_on ? (i - 1) : i;
                    if (j < nb) begin
                        pos     = CNT_W'(DATA_W - 1 - j);
                        use_val = 1'b1;
                    end
                end
            end else begin
                if (i < nb) begin
                    pos     = CNT_W'(DATA_W - nb + i);
                    use_val = 1'b1;
                end else if (fmt.sign_on && (i == nb)) begin
                    pos     = CNT_W'(WORD_W - 1);
                    use_val = 1'b1;
                end
            end
            bit_val = use_val & value[pos];
        end

        assign word[i] = bit_val;
    end

endmodule

// File: rtl/adcif_serial_slave.sv
module adcif_serial_slave
    import adcif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic [CHAN_W-1:0] mux_sel,
    output logic [ACQ_W-1:0]  acq_cycles,
    output logic              frame_done,
    output logic              conv_start
);

    typedef struct packed {
        logic               sclk_prev;
        logic               cs_prev;
        logic [CNT_W-1:0]   cnt;
        logic [INSTR_W-2:0] shift_in;
        fmt_t               cfg;
        logic [1:0]         acq;
        logic [CHAN_W-1:0]  chan;
        logic [WORD_W-1:0]  result;
        logic [CNT_W-1:0]   act_len;
        logic [WORD_W-1:0]  out_sr;
        logic               frame_done;
        logic               conv_start;
    } state_t;

    state_t st_d, st_q;

    logic               sclk_rise;
    logic               cs_rise;
    logic               last_bit;
    logic [INSTR_W-1:0] full_cmd;
    cmd_t               cmd;
    logic               conv_fire;
    logic               setup_fire;
    fmt_t               cfg_n;
    logic [1:0]         acq_n;
    logic [CHAN_W-1:0]  chan_n;
    logic [WORD_W-1:0]  result_n;
    logic [WORD_W-1:0]  stub_value;
    logic [WORD_W-1:0]  next_word;
    logic [CNT_W-1:0]   cnt_inc;

    logic [CNT_W-1:0]   cnt_w;
    logic [CNT_W-1:0]   len_w;

    assign full_cmd = {st_q.shift_in, sdi};

    adcif_decoder u_decoder (
        .cmd_word (full_cmd),
        .cmd      (cmd)
    );

    adcif_stub_source u_stub (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (conv_fire),
        .chan  (cmd.chan),
        .value (stub_value)
    );

    // Settings stage: what the configuration and held result become this cycle.
    always_comb begin
        sclk_rise  = sclk & ~st_q.sclk_prev & ~cs_n;
        cs_rise    = cs_n & ~st_q.cs_prev;
        last_bit   = sclk_rise && (st_q.cnt == CNT_W'(INSTR_W - 1));
        conv_fire  = last_bit && (cmd.kind == KIND_CONVERT);
        setup_fire = last_bit && (cmd.kind == KIND_SETUP);

        cfg_n    = st_q.cfg;
        acq_n    = st_q.acq;
        chan_n   = st_q.chan;
        result_n = st_q.result;
        if (conv_fire) begin
            cfg_n.res       = cmd.res;
            cfg_n.lsb_first = cmd.lsb_first;
            chan_n          = cmd.chan;
            result_n        = stub_value;
        end
        if (setup_fire) begin
            cfg_n.sign_on = cmd.sign_on;
            acq_n         = cmd.acq;
        end
    end

    adcif_word_builder u_builder (
        .fmt   (cfg_n),
        .value (result_n),
        .word  (next_word)
    );

    // Frame stage: bit counting, shifting and frame boundaries.
    always_comb begin
        st_d            = st_q;
        st_d.sclk_prev  = sclk;
        st_d.cs_prev    = cs_n;
        st_d.cfg        = cfg_n;
        st_d.acq        = acq_n;
        st_d.chan       = chan_n;
        st_d.result     = result_n;
        st_d.frame_done = 1'b0;
        st_d.conv_start = conv_fire;
        cnt_inc         = st_q.cnt + CNT_W'(1);

        if (sclk_rise) begin
            if (st_q.cnt < CNT_W'(INSTR_W)) begin
                st_d.shift_in = full_cmd[INSTR_W-2:0];
            end
            st_d.out_sr = st_q.out_sr >> 1;
            if (cnt_inc == st_q.act_len) begin
                st_d.cnt        = '0;
                st_d.frame_done = 1'b1;
                st_d.act_len    = frame_len(cfg_n);
                st_d.out_sr     = next_word;
            end else begin
                st_d.cnt = cnt_inc;
            end
        end else if (cs_rise && (st_q.cnt != '0)) begin
            st_d.cnt        = '0;
            st_d.frame_done = 1'b1;
            st_d.act_len    = frame_len(cfg_n);
            st_d.out_sr     = next_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sclk_prev  <= 1'b0;
            st_q.cs_prev    <= 1'b1;
            st_q.cnt        <= '0;
            st_q.shift_in   <= '0;
            st_q.cfg        <= FMT_RESET;
            st_q.acq        <= ACQ_RESET;
            st_q.chan       <= '0;
            st_q.result     <= '0;
            st_q.act_len    <= frame_len(FMT_RESET);
            st_q.out_sr     <= '0;
            st_q.frame_done <= 1'b0;
            st_q.conv_start <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo        = st_q.out_sr[0] & ~cs_n;
    assign mux_sel    = st_q.chan;
    assign acq_cycles = acq_clocks(st_q.acq);
    assign frame_done = st_q.frame_done;
    assign conv_start = st_q.conv_start;
    assign cnt_w      = st_q.cnt;
    assign len_w      = st_q.act_len;

endmodule

// File: rtl/adcif_checker.sv
module adcif_checker
    import adcif_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              sdo,
    input logic              frame_done,
    input logic              conv_start,
    input logic [CHAN_W-1:0] mux_sel,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  act_len
);

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        act_len inside {5'd8, 5'd9, 5'd12, 5'd13, 5'd16, 5'd17}); // R6

    AST_CNT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < act_len); // R10

    AST_LEN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (act_len != $past(act_len)) |-> frame_done); // R7

    AST_MUX_ONLY_ON_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (mux_sel != $past(mux_sel)) |-> conv_start); // R12

    AST_CONV_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> ($past(cnt) == CNT_W'(INSTR_W - 1))); // R2

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdo); // R13

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R11

endmodule

bind adcif_serial_slave adcif_checker u_adcif_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .frame_done (frame_done),
    .conv_start (conv_start),
    .mux_sel    (mux_sel),
    .cnt        (cnt_w),
    .act_len    (len_w)
);

// File: tb/test_adcif_serial_slave.sv
module test_adcif_serial_slave;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo;
    logic [3:0] mux_sel;
    logic [5:0] acq_cycles;
    logic       frame_done;
    logic       conv_start;

    int n_checks = 0;
    int n_errors = 0;
    int fd_cnt = 0;
    int cv_cnt = 0;
    bit finished = 1'b0;

    // reference model state
    logic [1:0]  m_res;
    logic        m_lsb;
    logic        m_sign;
    logic [3:0]  m_chan;
    logic [7:0]  m_seq;
    logic [16:0] m_result;
    int          m_len;
    logic [16:0] m_word;

    adcif_serial_slave i_adcif_serial_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .sdo        (sdo),
        .mux_sel    (mux_sel),
        .acq_cycles (acq_cycles),
        .frame_done (frame_done),
        .conv_start (conv_start)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (frame_done) fd_cnt++;
        if (conv_start) cv_cnt++;
    end

    function automatic int f_bits(input logic [1:0] r);
        if (r == 2'b01) return 8;
        if (r == 2'b10) return 16;
        return 12;
    endfunction

    function automatic logic [16:0] f_pick(input logic [16:0] v, input int idx);
        logic [16:0] t;
        t = v >> idx;
        return {16'b0, t[0]};
    endfunction

    function automatic logic [16:0] f_word(input logic [1:0] r, input logic lsb,
                                           input logic sgn, input logic [16:0] v);
        int          nb;
        int          p;
        logic [16:0] w;
        nb = f_bits(r);
        p  = 0;
        w  = '0;
        if (!lsb) begin
            if (sgn) begin
                w = w | (f_pick(v, 16) << p);
                p++;
            end
            for (int k = nb - 1; k >= 0; k--) begin
                w = w | (f_pick(v, 16 - nb + k) << p);
                p++;
            end
        end else begin
            for (int k = 0; k < nb; k++) begin
                w = w | (f_pick(v, 16 - nb + k) << p);
                p++;
            end
            if (sgn) w = w | (f_pick(v, 16) << p);
        end
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_step(input logic [7:0] cmd, input int nclk);
        if (nclk >= 8) begin
            if (cmd[7]) begin
                m_chan   = cmd[3:0];
                m_result = {m_seq[0], cmd[3:0], m_seq ^ 8'hA5, cmd[3:0]};
                m_seq    = m_seq + 8'd1;
                m_res    = cmd[6:5];
                m_lsb    = cmd[4];
            end else if (cmd[6]) begin
                m_sign = cmd[5];
            end
        end
        m_len  = f_bits(m_res) + int'(m_sign);
        m_word = f_word(m_res, m_lsb, m_sign, m_result);
    endtask

    // One frame: optionally strobes chip-select, shifts nclk bits, checks the word.
    task automatic xfer(input logic [7:0] cmd, input int nclk, input bit strobe,
                        input string req, output logic [16:0] got);
        logic [16:0] exp;
        logic [16:0] mask;
        logic [7:0]  t;
        int          fd_start;
        int          fd_last;
        exp      = m_word;
        got      = '0;
        fd_last  = 0;
        if (strobe) begin
            @(negedge clk) cs_n = 1'b0;
            repeat (2) @(negedge clk);
        end
        fd_start = fd_cnt;
        for (int i = 0; i < nclk; i++) begin
            got = got | ({16'b0, sdo} << i);
            if (i == nclk - 1) fd_last = fd_cnt;
            t   = cmd >> (7 - i);
            sdi = (i < 8) ? t[0] : 1'b0;
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        if (strobe) begin
            cs_n = 1'b1;
            repeat (3) @(negedge clk);
        end
        mask = (nclk >= 17) ? '1 : 17'((1 << nclk) - 1);
        chk((got & mask) == (exp & mask), req, "shifted word", got & mask, exp & mask);
        if (!strobe) begin
            // R10: no early boundary, exactly one at the last clock
            chk(fd_last == fd_start, "R10", "frame ended early", fd_last - fd_start, 0);
            chk(fd_cnt == fd_start + 1, "R10", "frame boundary count", fd_cnt - fd_start, 1);
        end
        model_step(cmd, nclk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        m_res = 2'b00; m_lsb = 1'b0; m_sign = 1'b1; m_chan = 4'd0;
        m_seq = 8'd0; m_result = '0;
        model_step(8'h00, 0);
        chk(acq_cycles == 6'd10, "R1", "reset acquisition", acq_cycles, 10);
        chk(mux_sel == 4'd0, "R1", "reset channel", mux_sel, 0);
        chk(sdo == 1'b0, "R13", "sdo while deselected", sdo, 0);
        chk(m_len == 13, "R1", "reset frame length model", m_len, 13);
    endtask

    task automatic t_first_conv;
        logic [16:0] got;
        int fd0, cv0;
        fd0 = fd_cnt; cv0 = cv_cnt;
        xfer(8'h83, 13, 1'b1, "R1", got);
        chk(got == 17'd0, "R5", "first word is reset result", got, 0);
        chk(cv_cnt == cv0 + 1, "R2", "conversion pulse", cv_cnt - cv0, 1);
        chk(fd_cnt == fd0 + 1, "R6", "13-clock frame ends once", fd_cnt - fd0, 1);
        chk(mux_sel == 4'd3, "R2", "channel from command", mux_sel, 3);
    endtask

    task automatic t_read;
        logic [16:0] got;
        int fd0, cv0;
        fd0 = fd_cnt; cv0 = cv_cnt;
        xfer(8'h20, 8, 1'b1, "R11", got);
        chk(cv_cnt == cv0, "R4", "read starts no conversion", cv_cnt - cv0, 0);
        chk(fd_cnt == fd0 + 1, "R11", "8-clock strobed read ends frame", fd_cnt - fd0, 1);
        chk(mux_sel == 4'd3 && acq_cycles == 6'd10, "R4", "read keeps settings",
            {mux_sel, acq_cycles}, {4'd3, 6'd10});
    endtask

    task automatic t_setup;
        logic [16:0] got;
        int cv0;
        cv0 = cv_cnt;
        xfer(8'h58, 13, 1'b1, "R5", got);
        chk(cv_cnt == cv0, "R3", "setup starts no conversion", cv_cnt - cv0, 0);
        chk(acq_cycles == 6'd34, "R3", "acquisition 34", acq_cycles, 34);
        chk(mux_sel == 4'd3, "R12", "setup keeps channel", mux_sel, 3);
    endtask

    task automatic t_format_next;
        logic [16:0] got;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        xfer(8'hB5, 12, 1'b0, "R7", got);
        chk(m_len == 8, "R6", "model length after 8-bit select", m_len, 8);
        xfer(8'h00, 8, 1'b0, "R9", got);
        @(negedge clk) cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mux_sel == 4'd5, "R12", "channel after conversion", mux_sel, 5);
    endtask

    task automatic t_order_sign;
        logic [16:0] got;
        xfer(8'h60, 8, 1'b1, "R7", got);
        chk(acq_cycles == 6'd6, "R3", "acquisition 6", acq_cycles, 6);
        xfer(8'hC9, 9, 1'b1, "R9", got);
        chk(got[8] == 1'b1, "R9", "sign sent last in LSB order", got[8], 1);
        xfer(8'hC2, 17, 1'b1, "R8", got);
        xfer(8'h00, 17, 1'b1, "R8", got);
        chk(got[0] == 1'b1, "R8", "sign sent first in MSB order", got[0], 1);
    endtask

    task automatic t_abort;
        logic [16:0] got;
        int fd0, cv0;
        fd0 = fd_cnt; cv0 = cv_cnt;
        xfer(8'h8F, 5, 1'b1, "R11", got);
        chk(cv_cnt == cv0, "R11", "partial command dropped", cv_cnt - cv0, 0);
        chk(fd_cnt == fd0 + 1, "R11", "deselect ends frame", fd_cnt - fd0, 1);
        chk(mux_sel == 4'd2, "R12", "channel kept after abort", mux_sel, 2);
        xfer(8'h00, 17, 1'b1, "R11", got);
    endtask

    task automatic t_idle_clock;
        logic [16:0] got;
        int fd0, cv0;
        fd0 = fd_cnt; cv0 = cv_cnt;
        sdi = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk) sclk = 1'b1;
            if (sdo !== 1'b0) chk(1'b0, "R13", "sdo high while deselected", sdo, 0);
            repeat (2) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        sdi = 1'b0;
        chk(fd_cnt == fd0 && cv_cnt == cv0, "R13", "idle clocks ignored",
            fd_cnt - fd0 + cv_cnt - cv0, 0);
        xfer(8'h00, 17, 1'b1, "R13", got);
    endtask

    task automatic t_stream;
        logic [16:0] got;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        xfer(8'h81, 17, 1'b0, "R10", got);
        xfer(8'hA6, 13, 1'b0, "R10", got);
        xfer(8'h00, 9, 1'b0, "R10", got);
        @(negedge clk) cs_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mux_sel == 4'd6, "R2", "stream channel", mux_sel, 6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first_conv();
        t_read();
        t_setup();
        t_format_next();
        t_order_sign();
        t_abort();
        t_idle_clock();
        t_stream();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule